// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A synthesizable model of a small synchronous static RAM whose bus is fully pipelined. Address, command and byte-lane enables are captured on one rising edge. The write data for a command, or its read result, sits two enabled edges later. Because a read and a write occupy the same pipeline slot, commands of either direction can be issued on every cycle, in any mix, with no idle cycle when the direction changes.

A command starts when `burst_adv` is low. At that point the address, the direction, the chip-select state and the burst order are captured. While `burst_adv` is high, an internal 2-bit counter steps through the other three words of the aligned four-word group, in linear or interleaved order.

There is no ready signal. The only flow control is `clken_n`. Every enabled cycle moves every stage by one slot. A consumer that cannot accept the read beat on `rdata`/`rvalid` must raise `clken_n`, which freezes the whole pipeline and the outputs. A producer must keep write data ready in its slot whenever the clock is enabled.

Top module: `zt_sram`

## Requirements
- R1: While `rst_n` is low and after its release, `rvalid` is 0 and `rdata` is 0 until a selected read reaches the output.
- R2: A selected read captured at enabled edge E0 places the stored word on `rdata` with `rvalid`=1 after enabled edge E2, the second enabled edge after E0.
- R3: A selected write captured at enabled edge E0 stores the `wdata` presented at enabled edge E2.
- R4: `lane_en[i]`=1, captured with the write's address, writes bits `[8i+7:8i]` of `wdata`. Lanes whose enable is 0 keep their stored contents.
- R5: Reads and writes may alternate on consecutive cycles with no gap. A read issued on the cycle right after a write to the same address returns the newly written word.
- R6: With `mode_ilv`=0 at the load, each cycle with `burst_adv`=1 issues the next beat of the same direction. Beat n uses low address bits (start + n) mod 4, and the upper address bits are unchanged.
- R7: With `mode_ilv`=1 at the load, beat n uses low address bits start XOR n.
- R8: A cycle is selected only when all three bits of `chip_sel` are 1 at the load. Otherwise the command and its burst beats are deselects that leave memory unchanged.
- R9: For write and deselect slots, `rvalid` is 0 and `rdata` is 0.
- R10: While `clken_n` is 1, every other input is ignored, and `rdata`, `rvalid` and all internal state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clken_n | input | 1 | High freezes the pipeline |
| burst_adv | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read (sampled at load) |
| lane_en | input | LANES | Per-byte write enables, captured with the address |
| chip_sel | input | 3 | All three high select the command |
| mode_ilv | input | 1 | 1 interleaved, 0 linear burst order |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, two enabled cycles after the address |
| rdata | output | LANES*LANE_W | Read data, zero for non-read slots |
| rvalid | output | 1 | High when `rdata` carries a read result |

## Verification
The checker examines every cycle for four properties. A frozen clock must leave the outputs unchanged. `rdata` must be zero whenever `rvalid` is low. A read or non-read in the second stage must map onto `rvalid` one enabled edge later. The upper address bits must stay fixed across burst advances. The bench's scenarios cover the rest: the data itself, the linear and interleaved beat orders, byte-lane merging, chip-select decoding and write-to-read forwarding across back-to-back cycles. Only a reference model of memory contents can check these.

// File: rtl/zt_pkg.sv
package zt_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVE = 1'b1} burst_ord_e;

  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input burst_ord_e ord);
    return (ord == ORD_INTERLEAVE) ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/zt_burst.sv
module zt_burst #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              wr_n,
  input  logic              sel_all,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lanes_in,
  output logic              c_vld,
  output logic              c_wr,
  output logic [ADDR_W-1:0] c_addr,
  output logic [LANES-1:0]  c_lanes
);
  import zt_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic              wr_q, vld_q;
  burst_ord_e        ord_q;
  logic [LANES-1:0]  lanes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      vld_q   <= 1'b0;
      ord_q   <= ORD_LINEAR;
      lanes_q <= '0;
    end else if (en) begin
      lanes_q <= lanes_in;
      if (load) begin
        base_q <= addr;
        cnt_q  <= '0;
        wr_q   <= ~wr_n;
        vld_q  <= sel_all;
        ord_q  <= burst_ord_e'(ilv);
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  assign c_vld   = vld_q;
  assign c_wr    = wr_q;
  assign c_lanes = lanes_q;
  assign c_addr  = {base_q[ADDR_W-1:2], beat_offset(base_q[1:0], cnt_q, ord_q)};
endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lanes[l]) arr[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
    end

    assign rd_word[l*LANE_W +: LANE_W] = arr[rd_addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clken_n,
  input  logic                    burst_adv,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_en,
  input  logic [2:0]              chip_sel,
  input  logic                    mode_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s2_vld, s2_wr;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_lanes;
  logic [DATA_W-1:0] rd_word;

  assign en = ~clken_n;

  zt_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .load(~burst_adv), .wr_n(wr_n),
    .sel_all(&chip_sel), .ilv(mode_ilv), .addr(addr), .lanes_in(lane_en),
    .c_vld(s1_vld), .c_wr(s1_wr), .c_addr(s1_addr), .c_lanes(s1_lanes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_vld   <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
    end else if (en) begin
      s2_vld   <= s1_vld;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .wr_en(en && rst_n && s2_vld && s2_wr), .wr_lanes(s2_lanes),
    .wr_addr(s2_addr), .wr_data(wdata), .rd_addr(s2_addr), .rd_word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (en) begin
      rvalid <= s2_vld && !s2_wr;
      rdata  <= (s2_vld && !s2_wr) ? rd_word : '0;
    end
  end
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clken_n,
  input logic              burst_adv,
  input logic              rvalid,
  input logic [DATA_W-1:0] rdata,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_vld,
  input logic              s2_wr
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clken_n |=> ($stable(rdata) && $stable(rvalid))); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0)); // R9

  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && s2_vld && !s2_wr) |=> rvalid); // R2

  AST_NONREAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && !(s2_vld && !s2_wr)) |=> !rvalid); // R8

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!clken_n && burst_adv) |=>
      (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))); // R6
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .burst_adv(burst_adv),
  .rvalid(rvalid), .rdata(rdata), .s1_addr(s1_addr),
  .s2_vld(s2_vld), .s2_wr(s2_wr)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clken_n = 1'b0, burst_adv = 1'b0, wr_n = 1'b1, mode_ilv = 1'b0;
  logic [1:0] lane_en = 2'b00;
  logic [2:0] chip_sel = 3'b000;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .clken_n(clken_n), .burst_adv(burst_adv),
    .wr_n(wr_n), .lane_en(lane_en), .chip_sel(chip_sel), .mode_ilv(mode_ilv),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  // reference model
  logic [DW-1:0] mm [1<<AW];
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  logic          b_wr = 0, b_vld = 0, b_ilv = 0;
  logic          hv [2], hw [2];
  logic [AW-1:0] ha [2];
  logic [1:0]    hl [2];
  logic [DW-1:0] hd [2];
  logic          exp_v = 0;
  logic [DW-1:0] exp_d = '0;

  function automatic logic [DW-1:0] fill(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (rvalid !== exp_v || rdata !== exp_d) begin
      n_bad++;
      $display("FAIL %s: rvalid/rdata = %0b/%h, expected %0b/%h",
               tag, rvalid, rdata, exp_v, exp_d);
    end
  endtask

  // one cycle: drive at negedge, edge, check at next negedge
  task automatic cyc(input logic stall, input logic adv, input logic wr,
                     input logic [2:0] cs, input logic ilv, input int a,
                     input logic [1:0] le, input logic [DW-1:0] d,
                     input string tag);
    logic [1:0] off;
    clken_n = stall; burst_adv = adv; wr_n = ~wr; chip_sel = cs;
    mode_ilv = ilv; addr = AW'(a); lane_en = le;
    wdata = stall ? ~hd[1] : hd[1];
    @(posedge clk);
    @(negedge clk);
    if (!stall) begin
      if (hv[1] && hw[1]) begin
        if (hl[1][0]) mm[ha[1]][7:0]  = hd[1][7:0];
        if (hl[1][1]) mm[ha[1]][15:8] = hd[1][15:8];
        exp_v = 0; exp_d = '0;
      end else if (hv[1]) begin
        exp_v = 1; exp_d = mm[ha[1]];
      end else begin
        exp_v = 0; exp_d = '0;
      end
      if (!adv) begin
        b_base = AW'(a); b_cnt = 0; b_wr = wr; b_vld = (cs == 3'b111); b_ilv = ilv;
      end else b_cnt = b_cnt + 2'd1;
      off = b_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
      hv[1] = hv[0]; hw[1] = hw[0]; ha[1] = ha[0]; hl[1] = hl[0]; hd[1] = hd[0];
      hv[0] = b_vld; hw[0] = b_wr; ha[0] = {b_base[AW-1:2], off}; hl[0] = le; hd[0] = d;
    end
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 3'b000, 0, 0, 2'b00, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      hv[i] = 0; hw[i] = 0; ha[i] = '0; hl[i] = '0; hd[i] = '0;
    end
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    idle("R1"); idle("R1");

    // R3: fill every word, single-beat writes
    for (int a = 0; a < (1<<AW); a++) cyc(0, 0, 1, 3'b111, 0, a, 2'b11, fill(a), "R3 R9");
    idle("R9"); idle("R9");

    // R2: read back every word
    for (int a = 0; a < (1<<AW); a++) cyc(0, 0, 0, 3'b111, 0, a, 2'b00, '0, "R2 R3");
    idle("R2"); idle("R2");

    // R6 / R7: read bursts from every start offset in both orders
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        cyc(0, 0, 0, 3'b111, m[0], 16 + 4*m + s, 2'b00, '0, m ? "R7" : "R6");
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 3'b000, 0, 0, 2'b00, '0, m ? "R7" : "R6");
      end
    // write burst, interleaved from offset 3, then linear read burst
    cyc(0, 0, 1, 3'b111, 1, 43, 2'b11, 16'hA000, "R7");
    for (int k = 1; k < 4; k++) cyc(0, 1, 1, 3'b000, 0, 0, 2'b11, 16'hA000 + 16'(k), "R7");
    cyc(0, 0, 0, 3'b111, 0, 40, 2'b00, '0, "R7 R6");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, 3'b000, 0, 0, 2'b00, '0, "R7 R6");
    idle("R6"); idle("R6");

    // R4: all lane-enable combinations
    for (int le = 0; le < 4; le++) begin
      cyc(0, 0, 1, 3'b111, 0, 5, 2'(le), 16'h1111 * 16'(le + 1), "R4");
      cyc(0, 0, 0, 3'b111, 0, 5, 2'b00, '0, "R4");
    end
    idle("R4"); idle("R4");

    // R5: write then read same address, every cycle
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 1, 3'b111, 0, 48 + i, 2'b11, 16'hC3C3 ^ 16'(i * 37), "R5");
      cyc(0, 0, 0, 3'b111, 0, 48 + i, 2'b00, '0, "R5");
    end
    idle("R5"); idle("R5");

    // R8: every chip-select pattern, then read back; deselect burst too
    for (int cs = 0; cs < 8; cs++) begin
      cyc(0, 0, 1, 3'(cs), 0, 9, 2'b11, 16'hD000 + 16'(cs), "R8");
      cyc(0, 0, 0, 3'b111, 0, 9, 2'b00, '0, "R8");
    end
    cyc(0, 0, 1, 3'b011, 0, 12, 2'b11, 16'hBAD0, "R8");
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 3'b111, 0, 0, 2'b11, 16'hBAD1, "R8");
    cyc(0, 0, 0, 3'b111, 0, 12, 2'b00, '0, "R8");
    cyc(0, 1, 0, 3'b000, 0, 0, 2'b00, '0, "R8");
    idle("R8"); idle("R8");

    // R10: stalls inside a mixed stream with junk on every input
    cyc(0, 0, 0, 3'b111, 0, 20, 2'b00, '0, "R10");
    cyc(0, 0, 1, 3'b111, 0, 21, 2'b01, 16'h7E7E, "R10");
    for (int k = 0; k < 3; k++) cyc(1, 0, 1, 3'b111, 1, 0, 2'b11, 16'hFFFF, "R10");
    cyc(0, 0, 0, 3'b111, 0, 21, 2'b00, '0, "R10");
    cyc(1, 0, 1, 3'b111, 0, 21, 2'b11, 16'h0000, "R10");
    cyc(0, 0, 0, 3'b111, 0, 0, 2'b00, '0, "R10");
    for (int k = 0; k < 4; k++) idle("R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: simulation hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule